// File: doc/BRIEF.md
# Tagged Receive Word Buffer with End/Error Status

This block sits between the receive side of an infrared serial link and the register bus. The receive logic pushes 32-bit words into a shallow buffer (two entries by default). Each word carries a set of condition tags along with it: end of frame, CRC error, receiver overrun, and a code for how many bytes of the word are valid. The tags stay attached to their word as it moves through the buffer. A bus read returns the oldest word and removes it. The tags of that oldest word are shown on status pins, so software can check them before it reads the data.

An end/error flag is raised whenever any stored word carries a tag. While the flag is up, the interrupt is asserted and the DMA request is held low. This lets software drain the buffer by hand and look at each word's tags as it goes. Software writes one to clear the flag, and DMA service then resumes. If a tagged word is still stored after the clear, the flag comes back on the next cycle.

The push side is a valid/ready stream. `push_ready` is high whenever a slot is free. A word offered while `push_ready` is low is not held for later: it is discarded, and the receiver-overrun tag is marked on the newest stored word. Readiness depends only on occupancy. A pop in the same cycle does not make room for that cycle's push.

Top module: `irx_tag_buffer`

## Requirements
- R1: After reset the buffer is empty. `push_ready` is 1, and `rd_data`, every status pin, `irq` and `dma_req` are 0.
- R2: `rd_data` shows the low 32 bits of the oldest stored entry. A cycle with `rd_strobe` high pops that entry at the clock edge. Words leave in the order they were accepted.
- R3: With DEPTH entries held, `push_ready` is 0. A push offered then is discarded: no stored word changes, and the discarded word never appears on `rd_data`.
- R4: A discarded push sets the overrun tag (entry bit 34) of the most recently stored entry.
- R5: `stat_eof`, `stat_crc_err` and `stat_ovr` show entry bits 32, 33 and 34 of the oldest entry, as they were pushed alongside that word. All three are 0 when the buffer is empty.
- R6: `stat_bytes` shows entry bits 36:35 of the oldest entry. The encoding is 00 = four valid bytes, 01 = one, 10 = two, 11 = three. Any nonzero code counts as a tag.
- R7: The end/error flag (`stat_eif`) is set one clock edge after a cycle in which any occupied entry has a tag set. `irq` equals this flag.
- R8: `dma_req` is 1 exactly when the buffer is non-empty and the end/error flag is 0.
- R9: `eif_clr` high at a clock edge clears the flag, and the clear wins over a set in that edge. If a tagged entry is still stored, the flag is set again at the following edge.
- R10: A read strobe while the buffer is empty leaves `rd_data` at 0 and changes neither occupancy nor flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Receive logic offers a word |
| push_ready | output | 1 | A slot is free; the offered word is accepted |
| push_data | input | 32 | Received data word |
| push_eof | input | 1 | Word ends a frame |
| push_crc_err | input | 1 | Frame check failed on this word |
| push_ovr | input | 1 | Receiver overran while building this word |
| push_bytes | input | 2 | Valid-byte code of this word |
| rd_strobe | input | 1 | Data register read; pops the oldest entry |
| rd_data | output | 32 | Data of the oldest entry, 0 when empty |
| eif_clr | input | 1 | Write-one-to-clear of the end/error flag |
| stat_eof | output | 1 | End-of-frame tag of the oldest entry |
| stat_crc_err | output | 1 | CRC-error tag of the oldest entry |
| stat_ovr | output | 1 | Overrun tag of the oldest entry |
| stat_bytes | output | 2 | Valid-byte code of the oldest entry |
| stat_eif | output | 1 | End/error-in-buffer flag |
| irq | output | 1 | Interrupt, level equal to the end/error flag |
| dma_req | output | 1 | Receive DMA request |

## Verification
Words go in with no tags, with each single tag, and with each nonzero byte code, so the status pins are shown to follow the word rather than a fixed slot. The buffer is filled until a push is refused. This separates a discarded word from one that overwrites a stored word, and shows the overrun mark landing on the newest word and not the oldest. Clears are issued while a tagged word is still stored, after it has gone, and in the same cycle as its pop. This tells the re-set path apart from a plain clear and shows the clear beating a pending set. A push in the same cycle as a pop, and a pop of an empty buffer, check the pointer wrap and the empty-read guard.

// File: rtl/irx_pkg.sv
package irx_pkg;
  parameter int DATA_W = 32;
  localparam int TAG_W = 5;
  localparam int ENTRY_W = DATA_W + TAG_W;

  typedef enum logic [1:0] {
    BYTES_4 = 2'b00,
    BYTES_1 = 2'b01,
    BYTES_2 = 2'b10,
    BYTES_3 = 2'b11
  } byte_cnt_e;

  // Field order fixes data at [31:0], eof 32, crc 33, ovr 34, bytes 36:35.
  typedef struct packed {
    byte_cnt_e         bytes;
    logic              ovr;
    logic              crc;
    logic              eof;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  function automatic logic entry_tagged(input rx_entry_t e);
    return e.eof | e.crc | e.ovr | (e.bytes != BYTES_4);
  endfunction
endpackage

// File: rtl/irx_push_gate.sv
module irx_push_gate (
  input  logic push_valid,
  input  logic rd_strobe,
  input  logic empty,
  input  logic full,
  output logic push_ready,
  output logic wr_en,
  output logic drop,
  output logic rd_en
);
  // Readiness depends on occupancy only; a same-cycle pop gives no room.
  assign push_ready = !full;
  assign wr_en      = push_valid && !full;
  assign drop       = push_valid && full;
  assign rd_en      = rd_strobe && !empty;
endmodule

// File: rtl/irx_slot_store.sv
module irx_slot_store
  import irx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  rx_entry_t wr_entry,
  input  logic      rd_en,
  input  logic      drop,
  output rx_entry_t head,
  output logic      empty,
  output logic      full,
  output logic      tag_any
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptr_prev(input logic [PTR_W-1:0] p);
    return (p == '0) ? LAST : p - 1'b1;
  endfunction

  logic [PTR_W-1:0] wr_ptr, rd_ptr, newest;
  logic [DEPTH-1:0] occ, slot_tag;
  rx_entry_t        slot [DEPTH];

  assign newest = ptr_prev(wr_ptr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_next(wr_ptr);
      if (rd_en) rd_ptr <= ptr_next(rd_ptr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic hit_wr, hit_rd, hit_ovr;
    assign hit_wr  = wr_en && (wr_ptr == PTR_W'(i));
    assign hit_rd  = rd_en && (rd_ptr == PTR_W'(i));
    assign hit_ovr = drop  && (newest == PTR_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ[i]  <= 1'b0;
        slot[i] <= '0;
      end else begin
        if (hit_wr) begin
          slot[i] <= wr_entry;
          occ[i]  <= 1'b1;
        end else if (hit_rd) begin
          occ[i]  <= 1'b0;
        end
        if (hit_ovr) slot[i].ovr <= 1'b1;
      end
    end

    assign slot_tag[i] = occ[i] && entry_tagged(slot[i]);
  end

  assign head    = slot[rd_ptr];
  assign empty   = (occ == '0);
  assign full    = (occ == '1);
  assign tag_any = |slot_tag;

  // R3: a push offered to a full buffer with no pop leaves it full
  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !rd_en) |=> full);

  // R4: a discarded push leaves a tagged entry behind
  p_drop_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> tag_any);

  // R2: a write into an empty buffer makes it non-empty
  p_push_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && empty) |=> !empty);
endmodule

// File: rtl/irx_eif_ctrl.sv
module irx_eif_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tag_any,
  input  logic eif_clr,
  input  logic empty,
  output logic eif,
  output logic irq,
  output logic dma_req
);
  always_ff @(posedge clk) begin
    if (!rst_n)       eif <= 1'b0;
    else if (eif_clr) eif <= 1'b0;
    else if (tag_any) eif <= 1'b1;
  end

  assign irq     = eif;
  assign dma_req = !empty && !eif;

  // R7: a tag seen without a clear raises the flag at the next edge
  p_tag_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_any && !eif_clr) |=> eif);

  // R7: the flag only rises when a tag was present
  p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eif) |-> $past(tag_any));

  // R9: a clear drops the flag at the next edge
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eif_clr |=> !eif);
endmodule

// File: rtl/irx_tag_buffer.sv
module irx_tag_buffer
  import irx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  output logic        push_ready,
  input  logic [31:0] push_data,
  input  logic        push_eof,
  input  logic        push_crc_err,
  input  logic        push_ovr,
  input  logic [1:0]  push_bytes,
  input  logic        rd_strobe,
  output logic [31:0] rd_data,
  input  logic        eif_clr,
  output logic        stat_eof,
  output logic        stat_crc_err,
  output logic        stat_ovr,
  output logic [1:0]  stat_bytes,
  output logic        stat_eif,
  output logic        irq,
  output logic        dma_req
);
  rx_entry_t wr_entry, head;
  logic      wr_en, rd_en, drop, empty, full, tag_any;

  assign wr_entry = '{bytes: byte_cnt_e'(push_bytes), ovr: push_ovr,
                      crc: push_crc_err, eof: push_eof, data: push_data};

  irx_push_gate u_gate (
    .push_valid (push_valid),
    .rd_strobe  (rd_strobe),
    .empty      (empty),
    .full       (full),
    .push_ready (push_ready),
    .wr_en      (wr_en),
    .drop       (drop),
    .rd_en      (rd_en)
  );

  irx_slot_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_entry (wr_entry),
    .rd_en    (rd_en),
    .drop     (drop),
    .head     (head),
    .empty    (empty),
    .full     (full),
    .tag_any  (tag_any)
  );

  irx_eif_ctrl u_eif (
    .clk     (clk),
    .rst_n   (rst_n),
    .tag_any (tag_any),
    .eif_clr (eif_clr),
    .empty   (empty),
    .eif     (stat_eif),
    .irq     (irq),
    .dma_req (dma_req)
  );

  assign rd_data      = empty ? '0 : head.data;
  assign stat_eof     = !empty && head.eof;
  assign stat_crc_err = !empty && head.crc;
  assign stat_ovr     = !empty && head.ovr;
  assign stat_bytes   = empty ? 2'b00 : head.bytes;

  // R10: a read of an empty buffer with no push leaves it empty
  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && empty && !push_valid) |=> (empty && rd_data == '0));

  // R8: while the interrupt is up, no DMA request is seen on the next edge either
  p_dma_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !eif_clr) |=> !dma_req);
endmodule

// File: tb/tb_irx_tag_buffer.sv
module tb_irx_tag_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 1'b0, push_ready;
  logic [31:0] push_data = '0;
  logic        push_eof = 1'b0, push_crc_err = 1'b0, push_ovr = 1'b0;
  logic [1:0]  push_bytes = 2'b00;
  logic        rd_strobe = 1'b0, eif_clr = 1'b0;
  logic [31:0] rd_data;
  logic        stat_eof, stat_crc_err, stat_ovr, stat_eif, irq, dma_req;
  logic [1:0]  stat_bytes;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  irx_tag_buffer dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .push_eof(push_eof), .push_crc_err(push_crc_err),
    .push_ovr(push_ovr), .push_bytes(push_bytes), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .eif_clr(eif_clr), .stat_eof(stat_eof),
    .stat_crc_err(stat_crc_err), .stat_ovr(stat_ovr), .stat_bytes(stat_bytes),
    .stat_eif(stat_eif), .irq(irq), .dma_req(dma_req)
  );

  // Tag nibble layout used below: {bytes[1:0], ovr, crc, eof}
  typedef struct packed {
    logic        psh;
    logic [31:0] d;
    logic [4:0]  tg;
    logic        rd;
    logic        clr;
    logic [31:0] e_rd;
    logic [4:0]  e_tg;
    logic        e_eif;
    logic        e_dma;
    logic        e_rdy;
  } vec_t;

  localparam int NVEC = 23;
  // Expected fields describe the state seen before the row's clock edge.
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 32'h11111111, 5'h00, 1'b0, 1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 1'b1}, // R1 empty
    '{1'b1, 32'h22222222, 5'h00, 1'b0, 1'b0, 32'h11111111, 5'h00, 1'b0, 1'b1, 1'b1}, // R2 R8
    '{1'b1, 32'h33333333, 5'h00, 1'b0, 1'b0, 32'h11111111, 5'h00, 1'b0, 1'b1, 1'b0}, // R3 full, drop
    '{1'b0, 32'h0,        5'h00, 1'b1, 1'b0, 32'h11111111, 5'h00, 1'b0, 1'b1, 1'b0}, // R2 pop
    '{1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 32'h22222222, 5'h04, 1'b1, 1'b0, 1'b1}, // R4 ovr on newest
    '{1'b0, 32'h0,        5'h00, 1'b0, 1'b1, 32'h22222222, 5'h04, 1'b1, 1'b0, 1'b1}, // R9 clear
    '{1'b0, 32'h0,        5'h00, 1'b1, 1'b0, 32'h22222222, 5'h04, 1'b0, 1'b1, 1'b1}, // R9 re-set
    '{1'b0, 32'h0,        5'h00, 1'b0, 1'b1, 32'h0,        5'h00, 1'b1, 1'b0, 1'b1}, // R3 33333333 gone
    '{1'b1, 32'hDEADBEEF, 5'h11, 1'b0, 1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 1'b1},
    '{1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 32'hDEADBEEF, 5'h11, 1'b0, 1'b1, 1'b1}, // R5 eof, R6 two
    '{1'b0, 32'h0,        5'h00, 1'b1, 1'b1, 32'hDEADBEEF, 5'h11, 1'b1, 1'b0, 1'b1}, // R7
    '{1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 1'b1}, // R9 clear wins
    '{1'b0, 32'h0,        5'h00, 1'b1, 1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 1'b1}, // R10 empty read
    '{1'b1, 32'h0000ABCD, 5'h1A, 1'b0, 1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 1'b1}, // R10 still empty
    '{1'b1, 32'h12345678, 5'h00, 1'b1, 1'b0, 32'h0000ABCD, 5'h1A, 1'b0, 1'b1, 1'b1}, // R5 crc, R6 three
    '{1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 32'h12345678, 5'h00, 1'b1, 1'b0, 1'b1}, // R7 sticky
    '{1'b0, 32'h0,        5'h00, 1'b0, 1'b1, 32'h12345678, 5'h00, 1'b1, 1'b0, 1'b1},
    '{1'b0, 32'h0,        5'h00, 1'b1, 1'b0, 32'h12345678, 5'h00, 1'b0, 1'b1, 1'b1}, // R8 resumed
    '{1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 1'b1},
    '{1'b1, 32'h000000AA, 5'h08, 1'b0, 1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 1'b1},
    '{1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 32'h000000AA, 5'h08, 1'b0, 1'b1, 1'b1}, // R6 one byte
    '{1'b0, 32'h0,        5'h00, 1'b1, 1'b1, 32'h000000AA, 5'h08, 1'b1, 1'b0, 1'b1},
    '{1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 32'h0,        5'h00, 1'b0, 1'b0, 1'b1}
  };

  function automatic logic [4:0] seen_tags();
    return {stat_bytes, stat_ovr, stat_crc_err, stat_eof};
  endfunction

  task automatic check(input logic ok, input string req, input int row,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s row %0d: actual %h expected %h", req, row, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(rd_data == 32'h0,   "R1 rd_data", -1, rd_data, 32'h0);
    check(seen_tags() == 5'h0, "R1 tags", -1, 32'(seen_tags()), 32'h0);
    check({stat_eif, irq, dma_req} == 3'b000, "R1 flags", -1,
          32'({stat_eif, irq, dma_req}), 32'h0);
    check(push_ready == 1'b1, "R1 push_ready", -1, 32'(push_ready), 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      push_valid   = VEC[i].psh;
      push_data    = VEC[i].d;
      push_eof     = VEC[i].tg[0];
      push_crc_err = VEC[i].tg[1];
      push_ovr     = VEC[i].tg[2];
      push_bytes   = VEC[i].tg[4:3];
      rd_strobe    = VEC[i].rd;
      eif_clr      = VEC[i].clr;
      #1;
      check(rd_data == VEC[i].e_rd, "R2 rd_data", i, rd_data, VEC[i].e_rd);
      check(seen_tags() == VEC[i].e_tg, "R5 R6 status tags", i,
            32'(seen_tags()), 32'(VEC[i].e_tg));
      check(stat_eif == VEC[i].e_eif && irq == VEC[i].e_eif, "R7 R9 eif/irq", i,
            32'({stat_eif, irq}), 32'({VEC[i].e_eif, VEC[i].e_eif}));
      check(dma_req == VEC[i].e_dma, "R8 dma_req", i, 32'(dma_req), 32'(VEC[i].e_dma));
      check(push_ready == VEC[i].e_rdy, "R3 push_ready", i,
            32'(push_ready), 32'(VEC[i].e_rdy));
    end

    // R1: reset in the middle of traffic empties the buffer and drops the flag
    @(negedge clk);
    push_valid = 1'b1; push_data = 32'hCAFEF00D; push_eof = 1'b1;
    push_crc_err = 1'b0; push_ovr = 1'b0; push_bytes = 2'b00;
    rd_strobe = 1'b0; eif_clr = 1'b0;
    @(negedge clk);
    push_valid = 1'b0; push_eof = 1'b0;
    @(negedge clk);
    #1;
    check(stat_eif == 1'b1 && rd_data == 32'hCAFEF00D, "R7 pre-reset", -2,
          rd_data, 32'hCAFEF00D);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rd_data == 32'h0 && seen_tags() == 5'h0, "R1 after reset data", -2,
          rd_data, 32'h0);
    check({stat_eif, irq, dma_req, push_ready} == 4'b0001, "R1 after reset flags", -2,
          32'({stat_eif, irq, dma_req, push_ready}), 32'h1);

    done = 1'b1;
    finish_run();
  end
endmodule